// File: doc/BRIEF.md
# Link Wake-Up Pulse Generator

This block runs on the physical-layer side of a serial bus node. Its job is to wake a link-layer controller that has gone to sleep. It keeps one request flag. The flag sets when the link is seen as inactive and a wake-up event arrives. While the flag is set, the block drives a square wave to the link. The flag clears once the link reports itself active again. A bus reset also clears it, unless an enabled interrupt is still pending. A status output shows whether the wave is running.

The link counts as active only when the power-status input is high and the link-control bit is 1. There are two kinds of wake-up event:
- a one-cycle strobe saying a link-on packet for this node was received;
- an interrupt flag, but only while its enable is set.

Packet decoding and interrupt sources are outside this block.

Top module: `lnk_wake_gen`

## Requirements
- R1: After synchronous reset, `wake_out` and `wake_busy` are 0, and they stay 0 until a wake-up event arrives while the link is inactive.
- R2: A `lnkon_pkt` pulse while the link is inactive (`pwr_ok`=0 or `lctrl`=0) raises `wake_busy` at the next clock edge.
- R3: While running, `wake_out` is low for HALF_CYC cycles and then high for HALF_CYC cycles, repeating. The low phase starts at the edge where `wake_busy` rises. The default is 4, which gives an 8-cycle period of about 162.8 ns at 49.152 MHz.
- R4: `phy_irq` is a wake-up event only while `irq_wake_en` is 1. With `irq_wake_en`=0 it has no effect.
- R5: A wake-up event while the link is active (`pwr_ok`=1 and `lctrl`=1) is ignored. This includes an event in the same cycle the link turns active.
- R6: When the link is active at an edge, `wake_busy` and `wake_out` are 0 after that edge and stay 0.
- R7: A `bus_rst` pulse with no enabled interrupt pending clears `wake_busy` and `wake_out` at the next edge.
- R8: A `bus_rst` pulse while `phy_irq` and `irq_wake_en` are both 1 leaves the wave running, with its phase undisturbed.
- R9: A `lnkon_pkt` pulse in the same cycle as `bus_rst`, with the link inactive, sets or keeps the request.
- R10: A further wake-up event while the wave is running does not restart its phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_ok | input | 1 | Link power-status indication, 1 = active |
| lctrl | input | 1 | Link-control bit |
| lnkon_pkt | input | 1 | One-cycle strobe: link-on packet for this node |
| phy_irq | input | 1 | Interrupt condition flag (level) |
| irq_wake_en | input | 1 | Lets `phy_irq` act as a wake-up event |
| bus_rst | input | 1 | One-cycle bus-reset strobe |
| wake_out | output | 1 | Wake-up square wave, registered |
| wake_busy | output | 1 | 1 while the wake-up wave is running |

## Verification
The properties assume that every input is synchronous to `clk` and is sampled only at rising edges. They also assume that `lnkon_pkt` and `bus_rst` are single-cycle strobes, while the other inputs are levels that may change on any cycle. The stimulus drives every input on the falling edge, pulses the strobes for exactly one cycle, and holds levels across several periods. It also puts events and link-state changes in the same cycle on purpose, to reach the priority cases.

// File: rtl/lnk_wake_pkg.sv
package lnk_wake_pkg;
  parameter int unsigned HALF_DEF = 4;

  typedef struct packed {
    logic pkt;
    logic irq;
    logic irq_en;
    logic bus_rst;
    logic pwr_ok;
    logic lctrl;
  } wake_in_t;
endpackage

// File: rtl/wake_req_ctl.sv
module wake_req_ctl
  import lnk_wake_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  wake_in_t in_s,
  output logic     req_nx,
  output logic     req_q
);
  logic link_up;
  logic irq_wake;

  always_comb begin
    link_up  = in_s.pwr_ok & in_s.lctrl;
    irq_wake = in_s.irq & in_s.irq_en;
    if (link_up)
      req_nx = 1'b0;
    else if (in_s.pkt | irq_wake)
      req_nx = 1'b1;
    else if (in_s.bus_rst & ~irq_wake)
      req_nx = 1'b0;
    else
      req_nx = req_q;
  end

  always_ff @(posedge clk) begin
    if (rst) req_q <= 1'b0;
    else     req_q <= req_nx;
  end
endmodule

// File: rtl/wake_clk_div.sv
module wake_clk_div #(
  parameter int unsigned HALF = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run_nx,
  input  logic run_q,
  output logic wake
);
  localparam int unsigned CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run_nx || !run_q) begin
      wake <= 1'b0;
      cnt  <= '0;
    end else if (cnt == LAST) begin
      wake <= ~wake;
      cnt  <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/lnk_wake_gen.sv
module lnk_wake_gen
  import lnk_wake_pkg::*;
#(
  parameter int unsigned HALF_CYC = HALF_DEF
) (
  input  logic clk,
  input  logic rst,
  input  logic pwr_ok,
  input  logic lctrl,
  input  logic lnkon_pkt,
  input  logic phy_irq,
  input  logic irq_wake_en,
  input  logic bus_rst,
  output logic wake_out,
  output logic wake_busy
);
  wake_in_t in_s;
  logic     req_nx;
  logic     req_q;

  always_comb begin
    in_s.pkt     = lnkon_pkt;
    in_s.irq     = phy_irq;
    in_s.irq_en  = irq_wake_en;
    in_s.bus_rst = bus_rst;
    in_s.pwr_ok  = pwr_ok;
    in_s.lctrl   = lctrl;
  end

  wake_req_ctl u_ctl (
    .clk    (clk),
    .rst    (rst),
    .in_s   (in_s),
    .req_nx (req_nx),
    .req_q  (req_q)
  );

  wake_clk_div #(.HALF(HALF_CYC)) u_div (
    .clk    (clk),
    .rst    (rst),
    .run_nx (req_nx),
    .run_q  (req_q),
    .wake   (wake_out)
  );

  assign wake_busy = req_q;
endmodule

// File: rtl/lnk_wake_chk.sv
module lnk_wake_chk (
  input logic clk,
  input logic rst,
  input logic pwr_ok,
  input logic lctrl,
  input logic lnkon_pkt,
  input logic phy_irq,
  input logic irq_wake_en,
  input logic bus_rst,
  input logic wake_out,
  input logic wake_busy
);
  // R1
  idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    !wake_busy |-> !wake_out);

  // R2
  pkt_start_chk: assert property (@(posedge clk) disable iff (rst)
    (!(pwr_ok && lctrl) && lnkon_pkt) |=> wake_busy);

  // R3
  start_low_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(wake_busy) |-> !wake_out);

  // R6
  link_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (pwr_ok && lctrl) |=> (!wake_busy && !wake_out));

  // R7
  brst_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rst && !(phy_irq && irq_wake_en) && !lnkon_pkt) |=> !wake_busy);

  // R8
  brst_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rst && phy_irq && irq_wake_en && !(pwr_ok && lctrl)) |=> wake_busy);
endmodule

bind lnk_wake_gen lnk_wake_chk u_chk (.*);

// File: tb/lnk_wake_gen_test.sv
`timescale 1ns/1ps
module lnk_wake_gen_test;
  localparam int HALF = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pwr_ok = 1'b0, lctrl = 1'b0, lnkon_pkt = 1'b0;
  logic phy_irq = 1'b0, irq_wake_en = 1'b0, bus_rst = 1'b0;
  logic wake_out, wake_busy;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  string tag = "R1";

  int m_req = 0;
  int m_age = 0;

  always #2.5 clk = ~clk;

  lnk_wake_gen #(.HALF_CYC(HALF)) uut (
    .clk(clk), .rst(rst), .pwr_ok(pwr_ok), .lctrl(lctrl),
    .lnkon_pkt(lnkon_pkt), .phy_irq(phy_irq), .irq_wake_en(irq_wake_en),
    .bus_rst(bus_rst), .wake_out(wake_out), .wake_busy(wake_busy)
  );

  // behavioural reference: request flag plus age since activation
  always @(posedge clk) begin
    if (rst) begin
      m_req = 0;
      m_age = 0;
    end else begin
      int nreq;
      bit act, irqw;
      act  = pwr_ok && lctrl;
      irqw = phy_irq && irq_wake_en;
      if (act) nreq = 0;
      else if (lnkon_pkt || irqw) nreq = 1;
      else if (bus_rst) nreq = 0;
      else nreq = m_req;
      if (nreq == 1 && m_req == 0) m_age = 0;
      else if (nreq == 1) m_age = m_age + 1;
      m_req = nreq;
    end
  end

  task automatic check(string t, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", t, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      check(tag, wake_busy, logic'(m_req == 1), "wake_busy");
      check(tag, wake_out, logic'(m_req == 1 && ((m_age / HALF) % 2) == 1), "wake_out");
    end
  end

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_pkt();
    lnkon_pkt = 1'b1; cyc(1); lnkon_pkt = 1'b0;
  endtask

  task automatic pulse_brst();
    bus_rst = 1'b1; cyc(1); bus_rst = 1'b0;
  endtask

  initial begin
    cyc(3);
    rst = 1'b0;
    cyc(1);
    // R1: reset state
    check("R1", wake_busy, 1'b0, "busy after reset");
    check("R1", wake_out, 1'b0, "wake after reset");
    cyc(3);

    // R5: events while link active are ignored
    tag = "R5";
    pwr_ok = 1'b1; lctrl = 1'b1;
    pulse_pkt();
    phy_irq = 1'b1; irq_wake_en = 1'b1; cyc(4); phy_irq = 1'b0; irq_wake_en = 1'b0;
    cyc(3);
    check("R5", wake_busy, 1'b0, "busy after ignored events");

    // R2 / R3: packet with lctrl=0 starts the wave
    tag = "R2";
    lctrl = 1'b0;
    cyc(1);
    pulse_pkt();
    check("R2", wake_busy, 1'b1, "busy after link-on packet");
    check("R3", wake_out, 1'b0, "first phase low");
    tag = "R3";
    cyc(3);
    check("R3", wake_out, 1'b0, "still low at end of first half");
    cyc(1);
    check("R3", wake_out, 1'b1, "high in second half");
    cyc(13);

    // R10: retrigger does not restart phase
    tag = "R10";
    pulse_pkt();
    cyc(10);

    // R6: link becomes active clears
    tag = "R6";
    lctrl = 1'b1;
    cyc(1);
    check("R6", wake_busy, 1'b0, "busy cleared by active link");
    check("R6", wake_out, 1'b0, "wake cleared by active link");
    cyc(5);

    // R4: interrupt without enable has no effect, with enable wakes
    tag = "R4";
    lctrl = 1'b0;
    phy_irq = 1'b1;
    cyc(6);
    check("R4", wake_busy, 1'b0, "irq without enable");
    irq_wake_en = 1'b1;
    cyc(1);
    check("R4", wake_busy, 1'b1, "irq with enable");
    cyc(5);

    // R8: bus reset with enabled interrupt pending keeps running
    tag = "R8";
    pulse_brst();
    check("R8", wake_busy, 1'b1, "busy kept over bus reset");
    cyc(6);
    phy_irq = 1'b0;
    cyc(3);

    // R7: bus reset without interrupt clears
    tag = "R7";
    pulse_brst();
    check("R7", wake_busy, 1'b0, "busy cleared by bus reset");
    check("R7", wake_out, 1'b0, "wake cleared by bus reset");
    cyc(4);

    // R7: enable set but interrupt low does not hold
    pulse_pkt();
    cyc(5);
    pulse_brst();
    check("R7", wake_busy, 1'b0, "bus reset clears with irq low");
    irq_wake_en = 1'b0;
    cyc(3);

    // R9: packet and bus reset in the same cycle
    tag = "R9";
    lnkon_pkt = 1'b1; bus_rst = 1'b1;
    cyc(1);
    lnkon_pkt = 1'b0; bus_rst = 1'b0;
    check("R9", wake_busy, 1'b1, "packet wins over bus reset");
    cyc(9);

    // R2: power-status low with lctrl=1 also counts as inactive
    tag = "R2";
    lctrl = 1'b1; pwr_ok = 1'b0;
    cyc(2);
    pulse_pkt();
    cyc(1);
    check("R2", wake_busy, 1'b1, "busy with pwr_ok low");
    cyc(6);
    tag = "R6";
    pwr_ok = 1'b1;
    cyc(1);
    check("R6", wake_busy, 1'b0, "busy cleared on power-status return");
    cyc(4);

    // R5: event in the same cycle the link turns active
    tag = "R5";
    lctrl = 1'b0;
    cyc(2);
    lctrl = 1'b1; lnkon_pkt = 1'b1;
    cyc(1);
    lnkon_pkt = 1'b0;
    check("R5", wake_busy, 1'b0, "same-cycle activation ignored");
    check("R5", wake_out, 1'b0, "same-cycle activation wake low");
    cyc(4);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule